// File: doc/BRIEF.md
# Descriptor Ring Queue Controller

This block is the per-queue control plane of a memory-to-memory copy engine whose work arrives as a circular ring of 32-byte descriptors in host memory. Software programs how many hardware queues are live. For each queue it then sets a ring length, a 64-bit ring base (48 bits kept) and a producer index, and the block tracks a hardware-owned consumer (read) index.

Whenever a live queue holds work, meaning its producer index differs from its read index, the block offers the host address of the next descriptor on a valid/ready fetch port. That address is the ring base plus the read index times 32. A round-robin arbiter shares the port among the queues. Each queue keeps at most one descriptor in flight. When the data mover reports completion on a one-cycle strobe, the read index steps forward and wraps at the ring length. At the same moment a sticky completion flag is set, and that flag drives the queue's own interrupt line. Software clears the flag by writing the status register with bit 0 at zero.

The register space is a flat word-addressed map. The queue-count register sits at byte 0x000, and queue n owns a 32-byte window at byte (n+1)*0x20. Accesses whose two low address bits are not zero are not decoded.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset, the queue-count register, every ring length, base, producer index, read index and completion flag read as zero, fetch_valid_o is low and every irq_o bit is low.
- R2: The queue-count register at byte 0x000 reads back what was written. A queue whose index is at or above that count ignores writes to its producer index, so the register keeps its old value, and it never requests a fetch.
- R3: Queue n's window starts at byte (n+1)*0x20. Within the window the word offsets are: ring length at 0x08, producer index at 0x10, base bits 31:0 at 0x18, and base bits 47:32 in the low 16 bits of 0x1C. The upper 16 bits of 0x1C read as zero. All of these read back what was written.
- R4: A live queue whose producer index differs from its read index, and that has no descriptor in flight, requests a fetch. fetch_addr_o is then base + read_index*32 and fetch_qid_o is the queue number.
- R5: A queue whose fetch has been accepted (fetch_valid_o and fetch_ready_i high at a clock edge) requests nothing more until a completion for that queue arrives.
- R6: Each accepted completion advances the read index (word 0x0C) by one, and the index returns to 0 when it reaches the ring length. Writes to 0x0C have no effect.
- R7: A completion sets bit 0 of the status word (0x14), and irq_o[n] equals that bit. Writing 0x14 with bit 0 at 0 clears the bit, and writing it with bit 0 at 1 leaves it as it is. A completion in the same cycle as a clearing write leaves the bit set.
- R8: When several queues request, the grant goes to the first requester after the last granted queue in ascending cyclic order. After reset, queue 0 is first in line.
- R9: A completion strobe for a queue with no descriptor in flight is ignored: the read index and the status bit do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| fetch_valid_o | output | 1 | Descriptor fetch request |
| fetch_ready_i | input | 1 | Fetch accepted when high together with fetch_valid_o |
| fetch_qid_o | output | QID_W | Queue of the offered fetch |
| fetch_addr_o | output | ADDR_W | Host address of the descriptor to fetch |
| done_valid_i | input | 1 | Descriptor completion strobe |
| done_qid_i | input | QID_W | Queue of the completed descriptor |
| irq_o | output | NUM_Q | Per-queue completion interrupt |

## Verification
The bench builds the block with four queues, 8-bit ring indices and 48-bit addresses. With four queues, the arbiter's pointer can wrap from queue 3 back to queue 0, and a queue-count of 2 leaves two real queues inactive to test against. With 8-bit indices, a ring of length 4 wraps after a few completions. Bases with a non-zero upper half show that the high register reaches the fetch address.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  localparam int unsigned WIN_BYTES  = 32;
  localparam int unsigned DESC_SHIFT = 5;

  // word offset inside a queue window (byte offset / 4)
  typedef enum logic [2:0] {
    OFF_RSV0    = 3'd0,
    OFF_RSV1    = 3'd1,
    OFF_LEN     = 3'd2,
    OFF_RDIDX   = 3'd3,
    OFF_WRIDX   = 3'd4,
    OFF_STAT    = 3'd5,
    OFF_BASE_LO = 3'd6,
    OFF_BASE_HI = 3'd7
  } win_off_e;
endpackage

// File: rtl/desc_ring_queue.sv
module desc_ring_queue
  import desc_ring_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned IDX_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              wr_en_i,
  input  win_off_e          off_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_take_i,
  input  logic              done_i,
  output logic              irq_o
);
  localparam int unsigned HI_W = ADDR_W - 32;
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic [IDX_W-1:0]  ring_len_q, rd_idx_q, wr_idx_q, rd_next;
  logic [ADDR_W-1:0] base_q;
  logic              stat_q, busy_q, done_ok, clr_stat;

  assign done_ok  = done_i & busy_q;
  assign clr_stat = wr_en_i & (off_i == OFF_STAT) & ~wr_data_i[0];
  assign rd_next  = ((rd_idx_q + IDX_ONE) == ring_len_q) ? '0 : rd_idx_q + IDX_ONE;

  assign fetch_req_o  = active_i & ~busy_q & (wr_idx_q != rd_idx_q);
  assign fetch_addr_o = base_q + ({{(ADDR_W-IDX_W){1'b0}}, rd_idx_q} << DESC_SHIFT);
  assign irq_o        = stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_len_q <= '0;
      rd_idx_q   <= '0;
      wr_idx_q   <= '0;
      base_q     <= '0;
      stat_q     <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      if (wr_en_i) begin
        case (off_i)
          OFF_LEN:     ring_len_q <= wr_data_i[IDX_W-1:0];
          OFF_WRIDX:   if (active_i) wr_idx_q <= wr_data_i[IDX_W-1:0];
          OFF_BASE_LO: base_q[31:0] <= wr_data_i;
          OFF_BASE_HI: base_q[ADDR_W-1:32] <= wr_data_i[HI_W-1:0];
          default: ;
        endcase
      end
      // set beats clear
      if (done_ok)       stat_q <= 1'b1;
      else if (clr_stat) stat_q <= 1'b0;
      if (done_ok) rd_idx_q <= rd_next;
      if (fetch_take_i)  busy_q <= 1'b1;
      else if (done_ok)  busy_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (off_i)
      OFF_LEN:     rd_data_o[IDX_W-1:0] = ring_len_q;
      OFF_RDIDX:   rd_data_o[IDX_W-1:0] = rd_idx_q;
      OFF_WRIDX:   rd_data_o[IDX_W-1:0] = wr_idx_q;
      OFF_STAT:    rd_data_o[0] = stat_q;
      OFF_BASE_LO: rd_data_o = base_q[31:0];
      OFF_BASE_HI: rd_data_o[HI_W-1:0] = base_q[ADDR_W-1:32];
      default: ;
    endcase
  end

  AST_TAKE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_take_i |-> fetch_req_o) else $error("take without request"); // R5
  AST_BUSY_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !fetch_take_i) else $error("second descriptor in flight"); // R5
  AST_RD_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_ok && ring_len_q > IDX_ONE) |=> rd_idx_q != $past(rd_idx_q)) else $error("read index stuck"); // R6
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_ok |=> $stable(rd_idx_q)) else $error("read index moved without completion"); // R6
  AST_IRQ_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_ok |=> irq_o) else $error("completion did not raise irq"); // R7
  AST_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !busy_q && !clr_stat) |=> $stable(stat_q)) else $error("stray completion changed status"); // R9
endmodule

// File: rtl/desc_ring_arb.sv
module desc_ring_arb #(
  parameter int unsigned N     = 16,
  parameter int unsigned SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             take_i,
  output logic             valid_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [N-1:0]     gnt_o
);
  logic [SEL_W-1:0] ptr_q;

  // first requester after the last grant, cyclic
  always_comb begin
    valid_o = 1'b0;
    sel_o   = '0;
    for (int k = 1; k <= int'(N); k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % int'(N);
      if (!valid_o && req_i[idx]) begin
        valid_o = 1'b1;
        sel_o   = SEL_W'(idx);
      end
    end
  end

  for (genvar g = 0; g < int'(N); g++) begin : g_gnt
    assign gnt_o[g] = take_i & valid_o & (sel_o == SEL_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ptr_q <= SEL_W'(N - 1);
    else if (take_i & valid_o) ptr_q <= sel_o;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)) else $error("multiple grants"); // R8
  AST_GNT_TO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> (|(gnt_o & req_i))) else $error("grant to idle queue"); // R8
endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import desc_ring_pkg::*;
#(
  parameter  int unsigned NUM_Q  = 16,
  parameter  int unsigned ADDR_W = 48,
  parameter  int unsigned IDX_W  = 16,
  localparam int unsigned REG_AW = $clog2((NUM_Q + 1) * WIN_BYTES),
  localparam int unsigned QID_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              fetch_valid_o,
  input  logic              fetch_ready_i,
  output logic [QID_W-1:0]  fetch_qid_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              done_valid_i,
  input  logic [QID_W-1:0]  done_qid_i,
  output logic [NUM_Q-1:0]  irq_o
);
  localparam int unsigned QCW   = $clog2(NUM_Q + 1);
  localparam int unsigned WIN_W = REG_AW - 5;

  logic [QCW-1:0]    q_count_q;
  logic [WIN_W-1:0]  win;
  win_off_e          off;
  logic              aligned;
  logic [NUM_Q-1:0]  q_active, q_we, q_req, q_take, q_done;
  logic [31:0]       q_rdata [NUM_Q];
  logic [ADDR_W-1:0] q_addr  [NUM_Q];

  assign win     = reg_addr_i[REG_AW-1:5];
  assign off     = win_off_e'(reg_addr_i[4:2]);
  assign aligned = (reg_addr_i[1:0] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_count_q <= '0;
    else if (reg_we_i && aligned && win == '0 && off == OFF_RSV0)
      q_count_q <= reg_wdata_i[QCW-1:0];
  end

  for (genvar n = 0; n < int'(NUM_Q); n++) begin : g_q
    assign q_active[n] = int'(q_count_q) > n;
    assign q_we[n]     = reg_we_i & aligned & (win == WIN_W'(n + 1));
    assign q_done[n]   = done_valid_i & (done_qid_i == QID_W'(n));

    desc_ring_queue #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
    ) u_queue (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .active_i     (q_active[n]),
      .wr_en_i      (q_we[n]),
      .off_i        (off),
      .wr_data_i    (reg_wdata_i),
      .rd_data_o    (q_rdata[n]),
      .fetch_req_o  (q_req[n]),
      .fetch_addr_o (q_addr[n]),
      .fetch_take_i (q_take[n]),
      .done_i       (q_done[n]),
      .irq_o        (irq_o[n])
    );
  end

  desc_ring_arb #(
    .N     (NUM_Q),
    .SEL_W (QID_W)
  ) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (q_req),
    .take_i  (fetch_ready_i),
    .valid_o (fetch_valid_o),
    .sel_o   (fetch_qid_o),
    .gnt_o   (q_take)
  );

  always_comb begin
    fetch_addr_o = '0;
    for (int n = 0; n < int'(NUM_Q); n++)
      if (fetch_qid_o == QID_W'(n)) fetch_addr_o = q_addr[n];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (aligned) begin
      if (win == '0 && off == OFF_RSV0) reg_rdata_o[QCW-1:0] = q_count_q;
      for (int n = 0; n < int'(NUM_Q); n++)
        if (win == WIN_W'(n + 1)) reg_rdata_o = q_rdata[n];
    end
  end

  AST_FETCH_LIVE_Q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> int'(fetch_qid_o) < int'(q_count_q)) else $error("fetch from inactive queue"); // R2
  AST_IRQ_QUIET_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> irq_o == '0) else $error("irq after reset"); // R1
endmodule

// File: tb/desc_ring_ctrl_tb.sv
`timescale 1ns/1ps
module desc_ring_ctrl_tb;
  localparam int NQ = 4;
  localparam int AW = 48;
  localparam int IW = 8;

  typedef struct packed {
    logic [1:0]    qid;
    logic [AW-1:0] addr;
  } fitem_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          fetch_valid;
  logic          fetch_rdy = 1'b1;
  logic [1:0]    fetch_qid;
  logic [AW-1:0] fetch_addr;
  logic          done_valid = 1'b0;
  logic [1:0]    done_qid = '0;
  logic [NQ-1:0] irq;

  fitem_t exp_q[$];
  int     done_q[$];
  bit     auto_done = 1'b0;
  bit     mon_on = 1'b0;
  string  cur_req = "R1";
  int     total = 0;
  int     bad = 0;

  localparam logic [AW-1:0] B0 = 48'h1234_5678_9A00;
  localparam logic [AW-1:0] B1 = 48'h0001_0000_1000;
  localparam logic [AW-1:0] B2 = 48'h0002_0000_2000;
  localparam logic [AW-1:0] B3 = 48'h0003_0000_3000;

  always #2 clk_i = ~clk_i;

  desc_ring_ctrl #(.NUM_Q(NQ), .ADDR_W(AW), .IDX_W(IW)) u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .reg_we_i      (reg_we),
    .reg_addr_i    (reg_addr),
    .reg_wdata_i   (reg_wdata),
    .reg_rdata_o   (reg_rdata),
    .fetch_valid_o (fetch_valid),
    .fetch_ready_i (fetch_rdy),
    .fetch_qid_o   (fetch_qid),
    .fetch_addr_o  (fetch_addr),
    .done_valid_i  (done_valid),
    .done_qid_i    (done_qid),
    .irq_o         (irq)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] wa(input int q, input int off);
    return 8'((q + 1) * 32 + off);
  endfunction

  // scoreboard monitor: compares every accepted fetch with the head of exp_q
  always @(negedge clk_i) begin
    #1;
    if (mon_on && fetch_valid && fetch_rdy) begin
      if (exp_q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL %s unexpected fetch act=q%0d/%h exp=none", cur_req, fetch_qid, fetch_addr);
      end else begin
        fitem_t e;
        e = exp_q.pop_front();
        chk(cur_req, {14'b0, fetch_qid, fetch_addr}, {14'b0, e.qid, e.addr});
      end
      if (auto_done) done_q.push_back(int'(fetch_qid));
    end
  end

  // completion responder
  always @(negedge clk_i) begin
    if (done_q.size() != 0) begin
      done_valid = 1'b1;
      done_qid   = 2'(done_q.pop_front());
    end else begin
      done_valid = 1'b0;
    end
  end

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk_i);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input string rq, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    reg_rd(a, d);
    chk(rq, 64'(d), 64'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || done_q.size() != 0) && n < 300) begin
      @(negedge clk_i);
      n++;
    end
    chk(cur_req, 64'(exp_q.size()), 64'd0);
    idle(3);
  endtask

  task automatic set_base(input int q, input logic [AW-1:0] b);
    reg_wr(wa(q, 8'h18), b[31:0]);
    reg_wr(wa(q, 8'h1C), {16'hFFFF, b[47:32]});
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    mon_on = 1'b1;
    idle(1);

    // R1 reset state
    cur_req = "R1";
    rd_chk("R1", 8'h00, 32'h0);
    rd_chk("R1", wa(0, 8'h08), 32'h0);
    rd_chk("R1", wa(0, 8'h0C), 32'h0);
    rd_chk("R1", wa(2, 8'h18), 32'h0);
    rd_chk("R1", wa(3, 8'h14), 32'h0);
    chk("R1", 64'(irq), 64'h0);
    chk("R1", 64'(fetch_valid), 64'h0);

    // R3 queue 0 layout
    cur_req = "R3";
    reg_wr(wa(0, 8'h08), 32'd4);
    set_base(0, B0);
    rd_chk("R3", wa(0, 8'h08), 32'd4);
    rd_chk("R3", wa(0, 8'h18), B0[31:0]);
    rd_chk("R3", wa(0, 8'h1C), 32'h0000_1234);

    // R2 doorbell ignored while queue count is 0
    cur_req = "R2";
    reg_wr(wa(0, 8'h10), 32'd2);
    idle(5);
    rd_chk("R2", wa(0, 8'h10), 32'd0);
    chk("R2", 64'(fetch_valid), 64'h0);
    reg_wr(8'h00, 32'd1);
    rd_chk("R2", 8'h00, 32'd1);

    // R4 fetch addresses
    cur_req = "R4";
    auto_done = 1'b1;
    exp_q.push_back('{qid: 2'd0, addr: B0});
    exp_q.push_back('{qid: 2'd0, addr: B0 + 48'd32});
    reg_wr(wa(0, 8'h10), 32'd2);
    rd_chk("R3", wa(0, 8'h10), 32'd2);
    drain();
    rd_chk("R6", wa(0, 8'h0C), 32'd2);
    rd_chk("R7", wa(0, 8'h14), 32'd1);
    chk("R7", 64'(irq[0]), 64'd1);

    // R7 clear semantics
    reg_wr(wa(0, 8'h14), 32'h1);
    rd_chk("R7", wa(0, 8'h14), 32'd1);
    reg_wr(wa(0, 8'h14), 32'hFFFF_FFFE);
    rd_chk("R7", wa(0, 8'h14), 32'd0);
    chk("R7", 64'(irq[0]), 64'd0);

    // R6 wrap at ring length 4
    cur_req = "R6";
    exp_q.push_back('{qid: 2'd0, addr: B0 + 48'd64});
    reg_wr(wa(0, 8'h10), 32'd3);
    drain();
    rd_chk("R6", wa(0, 8'h0C), 32'd3);
    exp_q.push_back('{qid: 2'd0, addr: B0 + 48'd96});
    reg_wr(wa(0, 8'h10), 32'd0);
    drain();
    rd_chk("R6", wa(0, 8'h0C), 32'd0);
    reg_wr(wa(0, 8'h0C), 32'd5);
    rd_chk("R6", wa(0, 8'h0C), 32'd0);
    chk("R6", 64'(fetch_valid), 64'h0);

    // R8 round robin, last grant was queue 0
    cur_req = "R8";
    reg_wr(8'h00, 32'd4);
    reg_wr(wa(1, 8'h08), 32'd8);
    reg_wr(wa(2, 8'h08), 32'd8);
    reg_wr(wa(3, 8'h08), 32'd8);
    set_base(1, B1);
    set_base(2, B2);
    set_base(3, B3);
    fetch_rdy = 1'b0;
    exp_q.push_back('{qid: 2'd1, addr: B1});
    exp_q.push_back('{qid: 2'd2, addr: B2});
    exp_q.push_back('{qid: 2'd3, addr: B3});
    exp_q.push_back('{qid: 2'd0, addr: B0});
    for (int q = 0; q < NQ; q++) reg_wr(wa(q, 8'h10), 32'd1);
    idle(2);
    chk("R8", 64'(fetch_valid), 64'd1);
    chk("R8", 64'(fetch_qid), 64'd1);
    fetch_rdy = 1'b1;
    drain();
    chk("R7", 64'(irq), 64'hF);

    // R5 one descriptor in flight
    cur_req = "R5";
    auto_done = 1'b0;
    exp_q.push_back('{qid: 2'd1, addr: B1 + 48'd32});
    reg_wr(wa(1, 8'h10), 32'd3);
    idle(10);
    chk("R5", 64'(exp_q.size()), 64'd0);
    chk("R5", 64'(fetch_valid), 64'd0);
    auto_done = 1'b1;
    exp_q.push_back('{qid: 2'd1, addr: B1 + 48'd64});
    @(posedge clk_i);
    done_q.push_back(1);
    drain();
    rd_chk("R5", wa(1, 8'h0C), 32'd3);

    // R9 stray completion
    cur_req = "R9";
    auto_done = 1'b0;
    reg_wr(wa(2, 8'h14), 32'h0);
    @(posedge clk_i);
    done_q.push_back(2);
    idle(4);
    rd_chk("R9", wa(2, 8'h0C), 32'd1);
    rd_chk("R9", wa(2, 8'h14), 32'd0);
    chk("R9", 64'(irq[2]), 64'd0);

    // R7 completion wins over a clearing write in the same cycle
    cur_req = "R7";
    exp_q.push_back('{qid: 2'd3, addr: B3 + 48'd32});
    reg_wr(wa(3, 8'h10), 32'd2);
    idle(6);
    chk("R7", 64'(exp_q.size()), 64'd0);
    @(posedge clk_i);
    done_q.push_back(3);
    reg_wr(wa(3, 8'h14), 32'h0);
    idle(2);
    rd_chk("R7", wa(3, 8'h14), 32'd1);
    chk("R7", 64'(irq[3]), 64'd1);
    rd_chk("R6", wa(3, 8'h0C), 32'd2);
    reg_wr(wa(3, 8'h14), 32'h0);
    rd_chk("R7", wa(3, 8'h14), 32'd0);

    // R2 lowering the queue count silences upper queues
    cur_req = "R2";
    reg_wr(8'h00, 32'd2);
    reg_wr(wa(3, 8'h10), 32'd5);
    reg_wr(wa(2, 8'h10), 32'd7);
    idle(6);
    rd_chk("R2", wa(3, 8'h10), 32'd2);
    rd_chk("R2", wa(2, 8'h10), 32'd1);
    chk("R2", 64'(fetch_valid), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule